// File: doc/BRIEF.md
# Multiplexed Display RAM Write Controller

This block takes display data bytes and scatters each one over a column-organised display memory of 60 columns by 4 rows. How a byte is spread depends on the drive mode. With one row per column (static), eight columns receive one bit each. In 1:2 mode four columns receive two bits each. In 1:3 mode three columns receive three bits, three bits and two bits. In 1:4 mode two columns receive four bits each. Bits are taken most significant first. They fill the rows of a column in ascending order before moving on to the next column.

A column pointer sets where the next byte lands, and it advances by the number of columns touched. A 3-bit device counter is compared with a strapped 3-bit identity. This lets several copies share one data stream: a copy whose counter differs from its identity discards the byte, but still moves its pointer. When the pointer runs past the last column, it wraps and the device counter steps up. The next device in a cascade therefore picks up the stream. A read port returns any column for inspection.

Top module: `mux_ram_loader`

## Requirements
- R1: After reset every cell reads 0, the pointer is 0 and valid, and the device counter is 0. A read of a column number of 60 or more returns 0.
- R2: A pulse on `ptr_load` sets the pointer to `ptr_val` and makes it valid. A value of 60 or more instead leaves the pointer invalid.
- R3: Mode 00 (static): data bit 7-k goes to row 0 of column ptr+k for k = 0..7, and the pointer advances by 8.
- R4: Mode 01 (1:2): data bit 7-k goes to row k%2 of column ptr+k/2, and the pointer advances by 4.
- R5: Mode 10 (1:3): data bit 7-k goes to row k%3 of column ptr+k/3. Row 2 of the third column keeps its previous value, and the pointer advances by 3.
- R6: Mode 11 (1:4): data bit 7-k goes to row k%4 of column ptr+k/4, and the pointer advances by 2.
- R7: When the device counter differs from `hw_sub`, a data byte changes no cell, but the pointer advances exactly as for a stored byte.
- R8: A pulse on `sel_load` loads the device counter with `sel_val`.
- R9: When an advance reaches or passes 60, the pointer wraps modulo 60 and the device counter increments by one (modulo 8). Cells that would fall beyond column 59 are not written.
- R10: `abort` marks the pointer invalid. Data bytes then change nothing until the next valid `ptr_load`.
- R11: A data byte presented in the same cycle as `abort`, `ptr_load` or `sel_load` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Drive mode: 00 static, 01 1:2, 10 1:3, 11 1:4 |
| hw_sub | input | 3 | Strapped device identity |
| abort | input | 1 | Invalidates the pointer |
| ptr_load | input | 1 | Load pointer strobe |
| ptr_val | input | 6 | Pointer value to load |
| sel_load | input | 1 | Device counter load strobe |
| sel_val | input | 3 | Device counter value to load |
| byte_vld | input | 1 | Data byte strobe |
| byte_dat | input | 8 | Data byte |
| rd_col | input | 6 | Column to read |
| rd_data | output | 4 | Rows 3..0 of the addressed column |

## Verification
The bench targets a byte that runs off the end of the memory. Written with a static byte at column 58, such a design would either spill into columns 0..5 or forget to bump the device counter, so the following bytes would land in the wrong device. The 1:3 case preloads row 2 of the third column with a 1, which catches a design that clears that cell. Blocked bytes are followed by a matching byte, because a design that freezes the pointer on a mismatch then writes to the wrong columns. Abort and command collisions are checked by showing that the memory stays unchanged.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  localparam int MRL_BYTE_W = 8;
  localparam int MRL_ROWS   = 4;

  // rows per column for a mode code
  function automatic int rows_of(input logic [1:0] m);
    return int'(m) + 1;
  endfunction

  // columns touched (pointer advance) for a mode code
  function automatic int step_of(input logic [1:0] m);
    return (MRL_BYTE_W + rows_of(m) - 1) / rows_of(m);
  endfunction

  // bit order index (0 = MSB) landing in a cell, or -1 for none
  function automatic int cell_index(input int col, input int row,
                                    input int ptr, input int rows);
    int off;
    int k;
    off = col - ptr;
    if (off < 0 || row >= rows) return -1;
    k = off * rows + row;
    return (k < MRL_BYTE_W) ? k : -1;
  endfunction

  // MSB-first bit pick
  function automatic logic pick_bit(input logic [MRL_BYTE_W-1:0] d, input int k);
    logic b;
    b = 1'b0;
    for (int i = 0; i < MRL_BYTE_W; i++)
      if (i == k) b = d[MRL_BYTE_W-1-i];
    return b;
  endfunction

  // next pointer value modulo the column count
  function automatic int wrap_ptr(input int p, input int s, input int cols);
    return (p + s >= cols) ? p + s - cols : p + s;
  endfunction

  function automatic logic wraps(input int p, input int s, input int cols);
    return (p + s >= cols);
  endfunction
endpackage

// File: rtl/mrl_ptr_ctrl.sv
module mrl_ptr_ctrl
  import mrl_pkg::*;
#(
  parameter int COLS  = 60,
  parameter int PTR_W = $clog2(COLS),
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             sel_load,
  input  logic [SUB_W-1:0] sel_val,
  input  logic             byte_take,
  input  logic [1:0]       mode,
  output logic [PTR_W-1:0] ptr,
  output logic             ptr_ok,
  output logic [SUB_W-1:0] sub,
  output logic             ovf
);
  int step;
  int nxt;

  always_comb begin
    step = step_of(mode);
    nxt  = wrap_ptr(int'(ptr), step, COLS);
    ovf  = byte_take && wraps(int'(ptr), step, COLS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      ptr_ok <= 1'b1;
      sub    <= '0;
    end else if (abort) begin
      ptr_ok <= 1'b0;
    end else begin
      if (ptr_load) begin
        if (int'(ptr_val) < COLS) begin
          ptr    <= ptr_val;
          ptr_ok <= 1'b1;
        end else begin
          ptr    <= '0;
          ptr_ok <= 1'b0;
        end
      end
      if (sel_load) sub <= sel_val;
      if (byte_take) begin
        ptr <= PTR_W'(nxt);
        if (ovf) sub <= sub + 1'b1;
      end
    end
  end

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < COLS);

  // R10
  abort_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !ptr_ok);

  // R9
  ovf_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> sub == $past(sub) + 1'b1);

  // R8
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && !abort) |=> sub == $past(sel_val));

  // R7
  take_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !ovf) |=> int'(ptr) > int'($past(ptr)));
endmodule

// File: rtl/mrl_unpack.sv
module mrl_unpack
  import mrl_pkg::*;
#(
  parameter int COLS  = 60,
  parameter int PTR_W = $clog2(COLS),
  localparam int CELLS = COLS * MRL_ROWS
) (
  input  logic                  fire,
  input  logic [1:0]            mode,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [MRL_BYTE_W-1:0] dat,
  output logic [CELLS-1:0]      wen,
  output logic [CELLS-1:0]      wdat
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < MRL_ROWS; r++) begin : g_row
      int k;
      assign k = cell_index(c, r, int'(ptr), rows_of(mode));
      assign wen[c*MRL_ROWS+r]  = fire && (k >= 0);
      assign wdat[c*MRL_ROWS+r] = pick_bit(dat, k);
    end
  end
endmodule

// File: rtl/mrl_cell_array.sv
module mrl_cell_array
  import mrl_pkg::*;
#(
  parameter int COLS  = 60,
  parameter int PTR_W = $clog2(COLS),
  localparam int CELLS = COLS * MRL_ROWS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CELLS-1:0]    wen,
  input  logic [CELLS-1:0]    wdat,
  input  logic [PTR_W-1:0]    rd_col,
  output logic [MRL_ROWS-1:0] rd_data
);
  logic [MRL_ROWS-1:0] mem [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[c] <= '0;
      end else begin
        for (int r = 0; r < MRL_ROWS; r++)
          if (wen[c*MRL_ROWS+r]) mem[c][r] <= wdat[c*MRL_ROWS+r];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < COLS; c++)
      if (int'(rd_col) == c) rd_data = mem[c];
  end
endmodule

// File: rtl/mux_ram_loader.sv
module mux_ram_loader
  import mrl_pkg::*;
#(
  parameter int COLS  = 60,
  parameter int SUB_W = 3,
  localparam int PTR_W = $clog2(COLS),
  localparam int CELLS = COLS * MRL_ROWS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic [SUB_W-1:0]      hw_sub,
  input  logic                  abort,
  input  logic                  ptr_load,
  input  logic [PTR_W-1:0]      ptr_val,
  input  logic                  sel_load,
  input  logic [SUB_W-1:0]      sel_val,
  input  logic                  byte_vld,
  input  logic [MRL_BYTE_W-1:0] byte_dat,
  input  logic [PTR_W-1:0]      rd_col,
  output logic [MRL_ROWS-1:0]   rd_data
);
  logic [PTR_W-1:0] ptr;
  logic             ptr_ok;
  logic [SUB_W-1:0] sub;
  logic             ovf;
  logic             byte_take;
  logic             sub_hit;
  logic             wr_fire;
  logic [CELLS-1:0] wen;
  logic [CELLS-1:0] wdat;

  assign byte_take = byte_vld && ptr_ok && !abort && !ptr_load && !sel_load;
  assign sub_hit   = (sub == hw_sub);
  assign wr_fire   = byte_take && sub_hit;

  mrl_ptr_ctrl #(.COLS(COLS), .PTR_W(PTR_W), .SUB_W(SUB_W)) u_ptr (
    .clk, .rst_n, .abort, .ptr_load, .ptr_val, .sel_load, .sel_val,
    .byte_take, .mode, .ptr, .ptr_ok, .sub, .ovf
  );

  mrl_unpack #(.COLS(COLS), .PTR_W(PTR_W)) u_unpack (
    .fire(wr_fire), .mode, .ptr, .dat(byte_dat), .wen, .wdat
  );

  mrl_cell_array #(.COLS(COLS), .PTR_W(PTR_W)) u_cells (
    .clk, .rst_n, .wen, .wdat, .rd_col, .rd_data
  );

  // R7
  block_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !sub_hit) |-> wen == '0);

  // R10
  dead_ptr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_ok |-> wen == '0);

  // R11
  cmd_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || ptr_load || sel_load) |-> wen == '0);

  // R5
  three_row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && mode == 2'b10 && int'(ptr) <= COLS - 3) |-> $countones(wen) == MRL_BYTE_W);

  // R3
  byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wen) <= MRL_BYTE_W);
endmodule

// File: tb/sim_mux_ram_loader.sv
`timescale 1ns/1ps
module sim_mux_ram_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] hw_sub = 3'd0;
  logic       abort = 1'b0;
  logic       ptr_load = 1'b0;
  logic [5:0] ptr_val = '0;
  logic       sel_load = 1'b0;
  logic [2:0] sel_val = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [5:0] rd_col = '0;
  logic [3:0] rd_data;

  int total = 0;
  int bad = 0;

  logic [3:0] m_mem [60];
  int m_ptr;
  bit m_ok;
  int m_sub;

  always #2 clk = ~clk;

  mux_ram_loader u0 (
    .clk, .rst_n, .mode, .hw_sub, .abort, .ptr_load, .ptr_val, .sel_load,
    .sel_val, .byte_vld, .byte_dat, .rd_col, .rd_data
  );

  // model of one byte: walk columns, then rows
  task automatic model_byte(input logic [1:0] md, input logic [7:0] d);
    int nr = int'(md) + 1;
    int cols = 0;
    int used = 0;
    while (used < 8) begin
      for (int r = 0; r < nr; r++) begin
        if (used < 8) begin
          if (m_sub == int'(hw_sub) && m_ptr + cols < 60)
            m_mem[m_ptr + cols][r] = d[7 - used];
          used++;
        end
      end
      cols++;
    end
    m_ptr = m_ptr + cols;
    if (m_ptr >= 60) begin
      m_ptr = m_ptr - 60;
      m_sub = (m_sub + 1) % 8;
    end
  endtask

  task automatic op(input bit a, input bit pl, input logic [5:0] pv,
                    input bit sl, input logic [2:0] sv,
                    input bit bv, input logic [7:0] bd);
    @(negedge clk);
    abort = a; ptr_load = pl; ptr_val = pv; sel_load = sl; sel_val = sv;
    byte_vld = bv; byte_dat = bd;
    @(negedge clk);
    abort = 0; ptr_load = 0; sel_load = 0; byte_vld = 0;
    if (a) m_ok = 0;
    else begin
      if (pl) begin
        if (pv < 60) begin m_ptr = int'(pv); m_ok = 1; end
        else begin m_ptr = 0; m_ok = 0; end
      end
      if (sl) m_sub = int'(sv);
      if (bv && !pl && !sl && m_ok) model_byte(mode, bd);
    end
  endtask

  task automatic check_ram(input string req);
    for (int c = 0; c < 60; c++) begin
      rd_col = 6'(c);
      #0.5;
      total++;
      if (rd_data !== m_mem[c]) begin
        bad++;
        $display("FAIL %s col %0d actual=%b expected=%b", req, c, rd_data, m_mem[c]);
      end
    end
  endtask

  task automatic check_col(input string req, input int c, input logic [3:0] exp);
    rd_col = 6'(c);
    #0.5;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s col %0d actual=%b expected=%b", req, c, rd_data, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sel;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 60; c++) m_mem[c] = '0;
    m_ptr = 0; m_ok = 1; m_sub = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and out-of-range read
    check_ram("R1");
    check_col("R1", 61, 4'b0000);

    // R3 static at pointer 0 (reset value), then continues at 8
    mode = 2'b00;
    op(0, 0, 0, 0, 0, 1, 8'hA5);
    op(0, 0, 0, 0, 0, 1, 8'h3C);
    check_ram("R3");

    // R2 / R4 1:2 at column 20
    mode = 2'b01;
    op(0, 1, 6'd20, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hB4);
    op(0, 0, 0, 0, 0, 1, 8'h69);
    check_ram("R4");

    // R5 preload ones with 1:4, then 1:3 keeps row 2 of third column
    mode = 2'b11;
    op(0, 1, 6'd30, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    mode = 2'b10;
    op(0, 1, 6'd30, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'h00);
    check_ram("R5");
    check_col("R5", 32, 4'b1100);

    // R6 1:4
    mode = 2'b11;
    op(0, 1, 6'd40, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'h5E);
    check_ram("R6");

    // R7 / R8 mismatch advances pointer, matching byte lands after it
    mode = 2'b01;
    op(0, 1, 6'd44, 0, 0, 0, 0);
    op(0, 0, 0, 1, 3'd4, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    op(0, 0, 0, 1, 3'd0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'h81);
    check_ram("R7");

    // R9 static at 58: only 58,59 written, wraps to 6, counter to 1
    mode = 2'b00;
    op(0, 1, 6'd58, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    check_ram("R9");
    hw_sub = 3'd1;
    op(0, 0, 0, 0, 0, 1, 8'hC3);
    check_ram("R9");
    hw_sub = 3'd0;

    // R2 out-of-range load invalidates
    op(0, 1, 6'd62, 0, 0, 0, 0);
    op(0, 0, 0, 1, 3'd0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    check_ram("R2");

    // R10 abort, bytes ignored until load
    op(0, 1, 6'd10, 0, 0, 0, 0);
    op(1, 0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'hFF);
    check_ram("R10");
    op(0, 1, 6'd10, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 8'h0F);
    check_ram("R10");

    // R11 byte colliding with commands ignored
    op(0, 1, 6'd50, 0, 0, 1, 8'hFF);
    op(0, 0, 0, 1, 3'd0, 1, 8'hFF);
    op(1, 0, 0, 0, 0, 1, 8'hFF);
    check_ram("R11");

    // random mix, all requirements R2..R11
    op(0, 1, 6'd0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) hw_sub = 3'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) mode = 2'($urandom_range(0, 3));
      sel = $urandom_range(0, 99);
      if (sel < 8)       op(0, 1, 6'($urandom_range(0, 63)), 0, 0, 0, 0);
      else if (sel < 14) op(0, 0, 0, 1, 3'($urandom_range(0, 1)), 0, 0);
      else if (sel < 17) op(1, 0, 0, 0, 0, 0, 0);
      else if (sel < 20) op(0, 1, 6'($urandom_range(0, 59)), 0, 0, 1, 8'($urandom));
      else               op(0, 0, 0, 0, 0, 1, 8'($urandom));
      check_ram("R2-mix R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule